// File: doc/BRIEF.md
# Self-Timed Page Write Controller

This block sits between a two-wire serial protocol engine and a non-volatile storage array. The engine hands it each received data byte of a write transaction as a strobe with an in-page offset. The block keeps the byte in a page buffer and marks that offset as filled. When the stop that closes the write arrives, the block opens a self-timed write window of fixed length. Inside that window it walks the page once and sends only the filled offsets to the array write port.

While the window is open, `busy` tells the protocol engine to ignore the bus and to withhold the acknowledge for a device address. A host can therefore poll with repeated device addresses until one is acknowledged. The block discards any strobe, transaction start or stop that arrives during the window. A high write-protect input cancels a pending commit at the stop and also masks every array write strobe.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and `arr_we` is 0.
- R2: A stop that arrives while the block is idle starts a busy window when `wp` is 0 and at least one byte has been buffered. `busy` goes to 1 on the clock edge that samples the stop and stays at 1 for exactly `WR_CYCLES` cycles.
- R3: During the busy window, every buffered offset is written to the array exactly once, in ascending offset order, with its buffered byte on `arr_data`. Offsets that received no byte are not written.
- R4: A later byte at an offset already filled in the same transaction replaces the earlier byte. Offsets past the page end therefore wrap onto the same page and overwrite it.
- R5: A stop sampled while `wp` is 1 starts no busy window and discards the buffer. `arr_we` is never 1 while `wp` is 1, even inside a busy window.
- R6: A stop with no buffered byte starts no busy window and produces no array write.
- R7: While `busy` is 1, `byte_we`, `txn_start` and `stop_evt` have no effect. Bytes strobed during the window are never committed.
- R8: A `txn_start` pulse clears every filled flag, so a stop that follows with no new bytes starts no busy window.
- R9: `arr_we` is 1 only while `busy` is 1.
- R10: After a busy window ends, all filled flags are clear, so a second stop with no new bytes starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Pulse: a new write transaction has been addressed |
| byte_we | input | 1 | Pulse: a complete data byte has been received |
| byte_off | input | OFF_W | Offset of the byte within the page |
| byte_data | input | DATA_W | Received data byte |
| stop_evt | input | 1 | Pulse: a stop condition has been detected |
| wp | input | 1 | Write protect; 1 blocks all array writes |
| busy | output | 1 | Self-timed write window in progress; the bus must be ignored |
| arr_we | output | 1 | Array write strobe |
| arr_off | output | OFF_W | Page offset of the array write |
| arr_data | output | DATA_W | Data for the array write |

## Verification
On every cycle, the assertions check four things. An array write happens only inside the window and never under write protect. The window opens only after a stop and closes only when its counter reaches the set length. The whole page has been walked before the window closes. The filled flags stay frozen inside the window. Some behaviours need the bench's scenarios to show them: which offsets are written, their order and their data, last-byte-wins overwrite and page wrap, and the discards. The discards covered are under write protect, after a transaction start, after a finished commit, and of traffic arriving inside the window. These are all end-to-end effects on the array port.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
   // Outcome of a stop seen while idle
   typedef enum logic [1:0] {
      STOP_NONE    = 2'd0,
      STOP_COMMIT  = 2'd1,
      STOP_DISCARD = 2'd2
   } stop_act_e;

   function automatic stop_act_e decide_stop(input logic stop, input logic prot,
                                             input logic have_data);
      if (!stop)          return STOP_NONE;
      else if (prot)      return STOP_DISCARD;
      else if (have_data) return STOP_COMMIT;
      else                return STOP_NONE;
   endfunction
endpackage

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned OFF_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr,
   input  logic              hold,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld,
   output logic              any_vld
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  vld;
   logic [DEPTH-1:0]  vld_nxt;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_off] <= wr_data;
   end

   always_comb begin
      vld_nxt = clr ? '0 : vld;
      if (wr_en) vld_nxt[wr_off] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= '0;
      else        vld <= vld_nxt;
   end

   assign rd_data = mem[rd_off];
   assign rd_vld  = vld[rd_off];
   assign any_vld = |vld;

   // R7
   vld_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && $past(hold)) |-> $stable(vld));
endmodule

// File: rtl/pwc_cycle_timer.sv
module pwc_cycle_timer #(
   parameter int unsigned CYCLES = 1000000,
   localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);
   logic [CNT_W-1:0] cnt;

   assign last = busy && (cnt == CNT_W'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (last) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R2
   window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cnt) == CNT_W'(CYCLES - 1)));
endmodule

// File: rtl/pwc_commit_scan.sv
module pwc_commit_scan #(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned OFF_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             busy,
   output logic [OFF_W-1:0] off,
   output logic             active,
   output logic             done
);
   logic [OFF_W:0] ptr;

   assign off    = ptr[OFF_W-1:0];
   assign done   = ptr[OFF_W];
   assign active = busy && !done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (start)  ptr <= '0;
      else if (active) ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
   import pwc_pkg::*;
#(
   parameter int unsigned PAGE_BYTES = 256,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WR_CYCLES  = 1000000,
   localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start,
   input  logic              byte_we,
   input  logic [OFF_W-1:0]  byte_off,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              stop_evt,
   input  logic              wp,
   output logic              busy,
   output logic              arr_we,
   output logic [OFF_W-1:0]  arr_off,
   output logic [DATA_W-1:0] arr_data
);
   generate
      if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (WR_CYCLES < PAGE_BYTES) begin : g_bad_cycles
         $error("WR_CYCLES must cover one pass over the page");
      end
      if (DATA_W == 0) begin : g_bad_width
         $error("DATA_W must be nonzero");
      end
   endgenerate

   logic      accept;
   logic      any_vld, rd_vld, win_last, scan_active, scan_done;
   logic      buf_clr;
   stop_act_e stop_act;
   logic [DATA_W-1:0] rd_data;

   assign accept   = !busy;
   assign stop_act = decide_stop(stop_evt && accept, wp, any_vld);
   assign buf_clr  = (txn_start && accept) || (stop_act == STOP_DISCARD) || win_last;

   pwc_page_buf #(.DEPTH(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (byte_we && accept),
      .wr_off  (byte_off),
      .wr_data (byte_data),
      .clr     (buf_clr),
      .hold    (busy),
      .rd_off  (arr_off),
      .rd_data (rd_data),
      .rd_vld  (rd_vld),
      .any_vld (any_vld)
   );

   pwc_cycle_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (stop_act == STOP_COMMIT),
      .busy  (busy),
      .last  (win_last)
   );

   pwc_commit_scan #(.DEPTH(PAGE_BYTES)) u_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (stop_act == STOP_COMMIT),
      .busy   (busy),
      .off    (arr_off),
      .active (scan_active),
      .done   (scan_done)
   );

   assign arr_we   = scan_active && rd_vld && !wp;
   assign arr_data = rd_data;

   // R9
   write_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   // R5
   wp_masks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp |-> !arr_we);

   // R2
   window_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt));

   // R5
   wp_stop_no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && wp && !busy) |=> !busy);

   // R3
   full_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(scan_done));
endmodule

// File: tb/page_write_ctrl_tb.sv
module page_write_ctrl_tb;
   localparam int PAGE = 256;
   localparam int LIM  = 300;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       txn_start = 1'b0, byte_we = 1'b0, stop_evt = 1'b0, wp = 1'b0;
   logic [7:0] byte_off = '0, byte_data = '0;
   logic       busy, arr_we;
   logic [7:0] arr_off, arr_data;

   int n_chk = 0, n_fail = 0;
   bit done_flag = 1'b0;
   logic [15:0] exp_q [$];
   int m_d [PAGE];
   bit m_v [PAGE];

   always #2.5 clk = ~clk;

   page_write_ctrl #(.PAGE_BYTES(PAGE), .DATA_W(8), .WR_CYCLES(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .byte_we(byte_we),
      .byte_off(byte_off), .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp),
      .busy(busy), .arr_we(arr_we), .arr_off(arr_off), .arr_data(arr_data));

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic model_clear();
      for (int i = 0; i < PAGE; i++) m_v[i] = 1'b0;
   endtask

   // monitor: pops the scoreboard on each array write (R3, R9)
   always @(negedge clk) begin
      if (rst_n && arr_we) begin
         chk(busy, "R9", "write outside window", 0, 1);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected write at offset", int'(arr_off), -1);
         end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(arr_off == e[15:8], "R3", "write offset", int'(arr_off), int'(e[15:8]));
            chk(arr_data == e[7:0], "R4", "write data", int'(arr_data), int'(e[7:0]));
         end
      end
   end

   task automatic put_byte(int off, int d, bit upd);
      byte_we = 1'b1; byte_off = 8'(off); byte_data = 8'(d);
      tick();
      byte_we = 1'b0;
      if (upd) begin
         m_d[off % PAGE] = d & 8'hFF;
         m_v[off % PAGE] = 1'b1;
      end
   endtask

   task automatic new_txn();
      txn_start = 1'b1; tick(); txn_start = 1'b0;
      model_clear();
   endtask

   // driver: pushes expected writes, pulses stop, measures the window
   task automatic stop_and_check(string req, bit mask_after);
      bit any = 1'b0;
      int n = 0;
      for (int i = 0; i < PAGE; i++) if (m_v[i]) any = 1'b1;
      if (!wp && any && !mask_after)
         for (int i = 0; i < PAGE; i++)
            if (m_v[i]) exp_q.push_back({8'(i), 8'(m_d[i])});
      model_clear();
      stop_evt = 1'b1; tick(); stop_evt = 1'b0;
      if (mask_after) wp = 1'b1;
      while (busy && n < LIM + 10) begin n++; tick(); end
      chk(n == ((!wp || mask_after) && any ? LIM : 0), req, "window length", n,
          ((!wp || mask_after) && any) ? LIM : 0);
      tick(); tick();
      chk(exp_q.size() == 0, req, "writes left pending", exp_q.size(), 0);
      wp = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) tick();
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(arr_we == 1'b0, "R1", "arr_we after reset", arr_we, 0);
      rst_n = 1'b1; tick();

      // R2 R3: single byte
      new_txn(); put_byte(5, 8'hA5, 1); stop_and_check("R2", 1'b0);

      // R3 R4: sparse bytes, edges, overwrite
      new_txn();
      put_byte(255, 8'h11, 1); put_byte(0, 8'h22, 1); put_byte(77, 8'h33, 1);
      put_byte(0, 8'h44, 1);
      stop_and_check("R3", 1'b0);

      // R4: more than a page, wraps and overwrites
      new_txn();
      for (int i = 0; i < 260; i++) put_byte(i % PAGE, (i * 7 + 3), 1);
      stop_and_check("R4", 1'b0);

      // R5: protected stop discards, then a fresh byte commits alone
      new_txn(); put_byte(9, 8'h99, 1); put_byte(10, 8'h98, 1);
      wp = 1'b1; stop_and_check("R5", 1'b0);
      new_txn(); put_byte(3, 8'h5C, 1); stop_and_check("R5", 1'b0);

      // R5: protect raised inside the window masks the writes
      new_txn(); put_byte(20, 8'h01, 1); put_byte(21, 8'h02, 1);
      stop_and_check("R5", 1'b1);

      // R6: empty transaction
      new_txn(); stop_and_check("R6", 1'b0);

      // R8: transaction start clears the filled flags
      put_byte(40, 8'h40, 0); new_txn(); stop_and_check("R8", 1'b0);

      // R7: traffic inside the window is ignored
      new_txn(); put_byte(1, 8'hC3, 1);
      for (int i = 0; i < PAGE; i++) if (m_v[i]) exp_q.push_back({8'(i), 8'(m_d[i])});
      model_clear();
      stop_evt = 1'b1; tick(); stop_evt = 1'b0;
      begin
         int n = 1;
         put_byte(2, 8'hEE, 0); n++;
         txn_start = 1'b1; tick(); txn_start = 1'b0; n++;
         stop_evt = 1'b1; tick(); stop_evt = 1'b0; n++;
         while (busy && n < LIM + 10) begin n++; tick(); end
         chk(n == LIM + 1, "R7", "window length with stray stop", n, LIM + 1);
      end
      tick(); tick();
      chk(exp_q.size() == 0, "R7", "writes left pending", exp_q.size(), 0);
      stop_and_check("R7", 1'b0);

      // R10: flags clear after commit
      new_txn(); put_byte(128, 8'h80, 1); stop_and_check("R10", 1'b0);
      stop_and_check("R10", 1'b0);

      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule